// File: doc/BRIEF.md
# Multiplier-Free Lookup-Table FIR Filter

This block is a finite impulse response filter that needs no multipliers. Its coefficients are fixed when it is elaborated. Each accepted two's-complement sample enters a tap history. The block then walks through the bits of every stored sample, least significant slice first. On each clock it takes one slice of `BITS_PER_CYCLE` bits from every tap. For each bit position in that slice, the bits taken from a group of taps form an address into a small precomputed table. Each table entry holds the sum of the coefficients that the address selects.

The taps are divided into groups of at most `PART_TAPS`. Each group has its own table, and the group results are added together. Each bit lane in a slice has its own copy of every table. A lane's result is weighted by its position in the slice before the lanes are summed. The combined value goes into an accumulator that shifts its fed-back value right by `BITS_PER_CYCLE` places on each step. Because of this, the final value comes out at the correct scale with no correction afterwards. The slice that holds the sign bit is subtracted rather than added.

Setting `BITS_PER_CYCLE` to 1 gives a bit-serial filter with the smallest area. Setting it to the sample width gives a single-cycle filter. Values in between trade table copies for cycles. An upstream source offers samples with `inValid` and must wait for `inReady`. Every result is announced by a one-cycle `outValid` pulse.

Top module: `daFirFilter`

## Requirements
- R1: While reset is held and after it is released, with no sample yet offered, `inReady` is 1, `outValid` is 0 and `outData` is 0.
- R2: Each result equals the exact full-precision sum over k of coefficient k times the k-th most recent accepted sample. k = 0 is the sample just accepted, and the history reads as zeros after reset. Coefficient k sits at bits [k*COEF_W +: COEF_W] of `COEFS`.
- R3: `outValid` is high for exactly one cycle. It rises after the DATA_W/BITS_PER_CYCLE-th rising edge that follows the edge on which a sample was accepted.
- R4: `inReady` is 0 from the accepting edge until the edge that raises `outValid`, and it is 1 while `outValid` is 1. An `inValid` offered while `inReady` is 0 is ignored and leaves the history unchanged.
- R5: Samples are two's complement, so the top bit carries negative weight. The most negative sample, -2^(DATA_W-1), alone in the history gives -2^(DATA_W-1) times coefficient 0.
- R6: `outData` changes only on a cycle in which `outValid` is 1, and it holds its value between pulses.
- R7: The results are identical for BITS_PER_CYCLE of 1, 2 and DATA_W. The only difference is the latency in R3.
- R8: The table groups need not divide the taps evenly. With 8 taps in groups of at most 3, the groups serve 3, 3 and 2 taps, and the results still meet R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A sample is offered on `inData` |
| inReady | output | 1 | The block is idle and takes the offered sample on this edge |
| inData | input | DATA_W | Two's-complement input sample |
| outValid | output | 1 | One-cycle pulse: `outData` holds a new result |
| outData | output | DATA_W+COEF_W+clog2(NUM_TAPS) | Signed filter result |

## Verification
The assertions assume that the source obeys the handshake: a sample counts only on an edge where `inValid` and `inReady` are both high. The accumulator's range assumes that `BITS_PER_CYCLE` divides `DATA_W`. The stimulus drives three builds of the block, with one, two and eight bits per cycle, in lockstep. It offers each new sample only when all three are idle. While they are busy, it deliberately raises `inValid` with junk data for the cycles in which each one should refuse it. Random samples are mixed with directed impulses at both extremes of the sample range.

// File: rtl/daFirPkg.sv
package daFirPkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;   // a sample is accepted this edge
    logic step;   // one bit slice is consumed this edge
    logic first;  // step works on the lowest slice
    logic last;   // step works on the slice holding the sign bit
  } daStrobes_t;

endpackage

// File: rtl/daTable.sv
module daTable #(
  parameter int COEF_W    = 8,
  parameter int NUM_TAPS  = 8,
  parameter int PART_TAPS = 3,
  parameter int BASE      = 0,
  parameter logic [NUM_TAPS*COEF_W-1:0] COEFS = '0,
  parameter int LUT_W     = COEF_W + $clog2(PART_TAPS) + 1
) (
  input  logic [PART_TAPS-1:0]    addr,
  output logic signed [LUT_W-1:0] entry
);

  localparam int DEPTH = 1 << PART_TAPS;

  // Sum of the coefficients whose tap bit is set in the address
  function automatic logic signed [LUT_W-1:0] entryFor(input int unsigned a);
    logic signed [LUT_W-1:0] s;
    logic signed [COEF_W-1:0] c;
    s = '0;
    for (int t = 0; t < PART_TAPS; t++) begin
      if (a[t] && (BASE + t < NUM_TAPS)) begin
        c = signed'(COEFS[(BASE + t)*COEF_W +: COEF_W]);
        s = s + LUT_W'(c);
      end
    end
    return s;
  endfunction

  logic signed [LUT_W-1:0] rom [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : gEntry
    assign rom[e] = entryFor(e);
  end

  assign entry = rom[addr];

endmodule

// File: rtl/daControl.sv
module daControl
  import daFirPkg::*;
#(
  parameter int SLICES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output logic       inReady,
  output daStrobes_t strobes
);

  localparam int CNT_W = (SLICES > 1) ? $clog2(SLICES) : 1;

  logic             busy;
  logic [CNT_W-1:0] sliceCnt;

  assign inReady       = !busy;
  assign strobes.load  = inValid && !busy;
  assign strobes.step  = busy;
  assign strobes.first = busy && (sliceCnt == '0);
  assign strobes.last  = busy && (sliceCnt == CNT_W'(SLICES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      sliceCnt <= '0;
    end else if (strobes.load) begin
      busy     <= 1'b1;
      sliceCnt <= '0;
    end else if (busy) begin
      if (strobes.last) begin
        busy     <= 1'b0;
        sliceCnt <= '0;
      end else begin
        sliceCnt <= sliceCnt + 1'b1;
      end
    end
  end

  AST_SLICE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (int'(sliceCnt) < SLICES));  // R3

  AST_IDLE_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sliceCnt == '0));  // R3

endmodule

// File: rtl/daDatapath.sv
module daDatapath
  import daFirPkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int COEF_W         = 8,
  parameter int NUM_TAPS       = 8,
  parameter int PART_TAPS      = 3,
  parameter int BITS_PER_CYCLE = 2,
  parameter logic [NUM_TAPS*COEF_W-1:0] COEFS = '0,
  parameter int OUT_W          = DATA_W + COEF_W + $clog2(NUM_TAPS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  daStrobes_t              strobes,
  input  logic [DATA_W-1:0]       inData,
  output logic                    outValid,
  output logic signed [OUT_W-1:0] outData
);

  localparam int NUM_PARTS = (NUM_TAPS + PART_TAPS - 1) / PART_TAPS;
  localparam int LUT_W     = COEF_W + $clog2(PART_TAPS) + 1;
  localparam int ACC_W     = OUT_W + DATA_W + 1;
  localparam int BPC       = BITS_PER_CYCLE;

  logic [DATA_W-1:0] tapLine [NUM_TAPS];  // history, index 0 newest
  logic [DATA_W-1:0] work    [NUM_TAPS];  // copies being sliced

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_TAPS; k++) begin
        tapLine[k] <= '0;
        work[k]    <= '0;
      end
    end else if (strobes.load) begin
      tapLine[0] <= inData;
      work[0]    <= inData;
      for (int k = 1; k < NUM_TAPS; k++) begin
        tapLine[k] <= tapLine[k-1];
        work[k]    <= tapLine[k-1];
      end
    end else if (strobes.step) begin
      for (int k = 0; k < NUM_TAPS; k++) begin
        work[k] <= work[k] >> BPC;
      end
    end
  end

  // One table copy per bit lane and per tap group
  logic [PART_TAPS-1:0]    addr  [NUM_PARTS][BPC];
  logic signed [LUT_W-1:0] entry [NUM_PARTS][BPC];

  for (genvar p = 0; p < NUM_PARTS; p++) begin : gPart
    for (genvar b = 0; b < BPC; b++) begin : gLane
      for (genvar t = 0; t < PART_TAPS; t++) begin : gBit
        if (p*PART_TAPS + t < NUM_TAPS) begin : gUsed
          assign addr[p][b][t] = work[p*PART_TAPS + t][b];
        end else begin : gPad
          assign addr[p][b][t] = 1'b0;
        end
      end
      daTable #(
        .COEF_W(COEF_W), .NUM_TAPS(NUM_TAPS), .PART_TAPS(PART_TAPS),
        .BASE(p*PART_TAPS), .COEFS(COEFS), .LUT_W(LUT_W)
      ) uTable (
        .addr(addr[p][b]),
        .entry(entry[p][b])
      );
    end
  end

  logic signed [ACC_W-1:0] cycleSum;
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] accBase;
  logic signed [ACC_W-1:0] accNext;

  always_comb begin
    logic signed [ACC_W-1:0] lane;
    cycleSum = '0;
    for (int b = 0; b < BPC; b++) begin
      lane = '0;
      for (int p = 0; p < NUM_PARTS; p++) begin
        lane = lane + ACC_W'(entry[p][b]);
      end
      if (strobes.last && (b == BPC - 1)) begin
        lane = -lane;  // sign bit carries negative weight
      end
      cycleSum = cycleSum + (lane <<< b);
    end
  end

  always_comb begin
    if (strobes.first) accBase = '0;
    else               accBase = acc >>> BPC;
    accNext = accBase + (cycleSum <<< (DATA_W - BPC));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc      <= '0;
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= strobes.step && strobes.last;
      if (strobes.step) acc <= accNext;
      if (strobes.step && strobes.last) outData <= accNext[OUT_W-1:0];
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && strobes.last) |->
      (accNext[ACC_W-1:OUT_W-1] == '0 || accNext[ACC_W-1:OUT_W-1] == '1));  // R2

  AST_NO_LOAD_WHILE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.load && strobes.step));  // R4

endmodule

// File: rtl/daFirFilter.sv
module daFirFilter
  import daFirPkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int COEF_W         = 8,
  parameter int NUM_TAPS       = 8,
  parameter int PART_TAPS      = 3,
  parameter int BITS_PER_CYCLE = 2,
  parameter logic [NUM_TAPS*COEF_W-1:0] COEFS =
    {8'h01, 8'hFD, 8'h40, 8'h80, 8'h7F, 8'h25, 8'hF4, 8'h05},
  parameter int OUT_W          = DATA_W + COEF_W + $clog2(NUM_TAPS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic [DATA_W-1:0]       inData,
  output logic                    outValid,
  output logic signed [OUT_W-1:0] outData
);

  localparam int SLICES = DATA_W / BITS_PER_CYCLE;

  if (PART_TAPS < 1 || PART_TAPS > 12) begin : gBadPart
    $error("PART_TAPS must lie in 1..12");
  end
  if (BITS_PER_CYCLE < 1 || (DATA_W % BITS_PER_CYCLE) != 0) begin : gBadRadix
    $error("BITS_PER_CYCLE must divide DATA_W");
  end

  daStrobes_t strobes;

  daControl #(.SLICES(SLICES)) uControl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .inReady(inReady), .strobes(strobes)
  );

  daDatapath #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .NUM_TAPS(NUM_TAPS),
    .PART_TAPS(PART_TAPS), .BITS_PER_CYCLE(BITS_PER_CYCLE),
    .COEFS(COEFS), .OUT_W(OUT_W)
  ) uDatapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inData(inData),
    .outValid(outValid), .outData(outData)
  );

  AST_RESULT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && strobes.last) |=> outValid);  // R3

  AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (!inReady || outValid));  // R4

  AST_READY_WITH_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> inReady);  // R4

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outData));  // R6

endmodule

// File: tb/daFirFilter_bench.sv
`timescale 1ns/1ps
module daFirFilter_bench;

  localparam int DATA_W = 8;
  localparam int COEF_W = 8;
  localparam int NT     = 8;
  localparam int OUT_W  = DATA_W + COEF_W + $clog2(NT);
  localparam logic [NT*COEF_W-1:0] CF =
    {8'h01, 8'hFD, 8'h40, 8'h80, 8'h7F, 8'h25, 8'hF4, 8'h05};
  localparam int NV = 3;
  localparam int LG [NV] = '{2, 1, 8};  // bits per cycle per build
  localparam int MAXS = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [DATA_W-1:0] inData = '0;
  logic vld [NV];
  logic rdy [NV];
  logic ov  [NV];
  logic signed [OUT_W-1:0] od [NV];

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  int hist [NT];

  always #2.5 clk = ~clk;

  daFirFilter #(.BITS_PER_CYCLE(LG[0]), .COEFS(CF)) u_daFirFilter (
    .clk(clk), .rstN(rstN), .inValid(vld[0]), .inReady(rdy[0]),
    .inData(inData), .outValid(ov[0]), .outData(od[0]));
  daFirFilter #(.BITS_PER_CYCLE(LG[1]), .COEFS(CF)) u_daFirFilterSerial (
    .clk(clk), .rstN(rstN), .inValid(vld[1]), .inReady(rdy[1]),
    .inData(inData), .outValid(ov[1]), .outData(od[1]));
  daFirFilter #(.BITS_PER_CYCLE(LG[2]), .COEFS(CF)) u_daFirFilterParallel (
    .clk(clk), .rstN(rstN), .inValid(vld[2]), .inReady(rdy[2]),
    .inData(inData), .outValid(ov[2]), .outData(od[2]));

  function automatic int coefAt(input int k);
    logic signed [COEF_W-1:0] c;
    c = signed'(CF[k*COEF_W +: COEF_W]);
    return int'(c);
  endfunction

  function automatic int slicesOf(input int i);
    return DATA_W / LG[i];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Offer one sample to all builds while idle; optionally push junk while busy
  task automatic send(input logic [DATA_W-1:0] x, input bit junk, input string req);
    int expVal;
    int s;
    for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = int'(signed'(x));
    expVal = 0;
    for (int k = 0; k < NT; k++) expVal += coefAt(k) * hist[k];
    inData = x;
    for (int i = 0; i < NV; i++) vld[i] = 1'b1;
    for (int c = 0; c <= MAXS; c++) begin
      @(negedge clk);
      for (int i = 0; i < NV; i++) begin
        s = slicesOf(i);
        if (c == s) begin
          check(ov[i] == 1'b1, "R3 valid pulse", int'(ov[i]), 1);
          check(int'(od[i]) == expVal, {req, " R2 R7 R8 result"}, int'(od[i]), expVal);
          check(rdy[i] == 1'b1, "R4 ready with result", int'(rdy[i]), 1);
        end else if (c < s) begin
          check(ov[i] == 1'b0, "R3 early valid", int'(ov[i]), 0);
          check(rdy[i] == 1'b0, "R4 busy ready", int'(rdy[i]), 0);
        end else if (c == s + 1) begin
          check(ov[i] == 1'b0, "R3 single pulse", int'(ov[i]), 0);
          check(int'(od[i]) == expVal, "R6 hold", int'(od[i]), expVal);
        end
      end
      for (int i = 0; i < NV; i++) vld[i] = junk && (c < slicesOf(i));
      inData = junk ? DATA_W'($urandom) : x;
    end
    for (int i = 0; i < NV; i++) vld[i] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < NV; i++) vld[i] = 1'b0;
    for (int k = 0; k < NT; k++) hist[k] = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      check(rdy[i] == 1'b1 && ov[i] == 1'b0 && od[i] == '0, "R1 in reset", int'(od[i]), 0);
    end
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      check(rdy[i] == 1'b1, "R1 ready", int'(rdy[i]), 1);
      check(ov[i] == 1'b0, "R1 valid", int'(ov[i]), 0);
      check(od[i] == '0, "R1 data", int'(od[i]), 0);
    end
    // Unit impulse walks through every tap (R2, R8)
    send(8'h01, 1'b0, "R2 impulse");
    for (int k = 1; k < NT; k++) send(8'h00, 1'b0, "R2 impulse tail");
    // Full-scale negative impulse (R5), with junk offered while busy (R4)
    send(8'h80, 1'b1, "R5 negative impulse");
    for (int k = 1; k < NT; k++) send(8'h00, 1'b1, "R5 R4 tail");
    // Largest positive run and alternating extremes
    for (int k = 0; k < NT; k++) send(8'h7F, 1'b0, "R2 max run");
    for (int k = 0; k < NT; k++) send((k % 2) ? 8'h80 : 8'h7F, 1'b1, "R5 alternating");
    // Random samples, half with junk offered while busy (R4)
    for (int n = 0; n < 200; n++) send(DATA_W'($urandom), n[0], "R2 random");
    summary();
  end

endmodule